// File: doc/BRIEF.md
# Bubble-Free Flow-Through Synchronous SRAM

This block is a synthesizable synchronous SRAM whose bus never loses a cycle when traffic switches between reads and writes. Each operation is in two stages. On one rising edge the block samples the address, the command and the byte enables. In the next cycle it moves that operation's data. A read drives the array word straight onto the output in that cycle, with no output register. A write picks up the bus data at the edge that closes the cycle. Because every operation uses the same two-stage timing, a read can follow a write in the next cycle, and a write can follow a read, with no idle cycle between them.

A new operation starts only when all three chip selects are active and the load/advance input selects load. With advance selected, an internal two-bit beat counter steps the address through the other words of a four-word group. The step is linear or interleaved. The operation type does not change during a burst. An active-low clock enable freezes the whole pipeline while it is deasserted. An asynchronous output enable can remove read data from the bus at any moment. The bidirectional data bus is split into an input, an output and an output-enable port.

Top module: `nobubble_sram`

## Requirements
- R1: A read that is loaded at edge N drives the addressed word on `dq_o`, with `dq_oe_o`=1, for the whole cycle after edge N. No extra register stage sits in that path.
- R2: A write loaded at edge N takes `dq_i` at edge N+1. It updates only the byte lanes whose `byte_en_ni` bit was 0 at edge N. Bit k covers `dq_i[8k+7:8k]`.
- R3: While `oe_ni` is 1, `dq_oe_o` is 0. This holds at any time, independent of the clock.
- R4: While `clk_en_ni` is 1, the block ignores every synchronous input. The array, the pending operation and the burst state keep their values, so `dq_o`/`dq_oe_o` stay unchanged.
- R5: A load (`adv_i`=0) with `ce1_ni`=1, `ce2_i`=0 or `ce2b_ni`=1 starts no operation. `dq_oe_o` is 0 in the following cycle. A write already pending still completes at that edge.
- R6: `adv_i`=1 after a selected load steps the beat counter. The previous read or write type is kept. With `burst_ilv_i`=0 at the load, the two low address bits are base+count mod 4.
- R7: With `burst_ilv_i`=1 at the load, the two low address bits are base XOR count.
- R8: After the fourth beat the counter wraps to the starting address. Further advances repeat the same four addresses.
- R9: An advance that follows a deselecting load starts nothing, and `dq_oe_o` stays 0.
- R10: After reset no operation is pending, and `dq_oe_o` is 0.
- R11: A write at edge N followed by a read of the same address at edge N+1 returns the newly written data, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high stalls everything |
| ce1_ni | input | 1 | Chip select 1, active low |
| ce2_i | input | 1 | Chip select 2, active high |
| ce2b_ni | input | 1 | Chip select 3, active low |
| rnw_i | input | 1 | 1 = read, 0 = write |
| adv_i | input | 1 | 1 = advance burst, 0 = load new address |
| burst_ilv_i | input | 1 | Burst order sampled at load: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | Word address |
| byte_en_ni | input | DATA_W/BYTE_W | Byte lane write enables, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_i | input | DATA_W | Write data bus |
| dq_o | output | DATA_W | Read data bus, flow-through from the array |
| dq_oe_o | output | 1 | Bus drive enable for dq_o |

## Verification
On every cycle, the assertions check the following:
- the output enable blanking the bus (R3);
- stall cycles leaving the pending operation and the beat counter unchanged (R4);
- a deselecting load, or an advance after one, giving an undriven bus in the next cycle (R5, R9);
- a selected read load driving the bus in the next cycle unless it is blanked (R1);
- each advance stepping the two-bit counter modulo four (R6, R8).

Data values need the bench's scenarios and its shadow memory. These scenarios cover:
- the linear and interleaved address sequences and their wrap;
- merging of partial byte lanes;
- same-address write-then-read with no gap;
- a stalled write that completes late;
- a write that was presented during a stall and must have left the array untouched.

// File: rtl/nb_sram_pkg.sv
package nb_sram_pkg;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  function automatic logic [1:0] beat_offset(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input burst_order_e ord);
    return (ord == ORDER_INTERLEAVED) ? (base ^ cnt) : 2'(base + cnt);
  endfunction
endpackage

// File: rtl/nb_burst_gen.sv
module nb_burst_gen
  import nb_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ilv_i,
  output logic [ADDR_W-1:0] cur_addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  burst_order_e      ord_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      ord_q  <= ORDER_LINEAR;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
      ord_q  <= burst_order_e'(ilv_i);
    end else if (step_i) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  assign cur_addr_o = {base_q[ADDR_W-1:2], beat_offset(base_q[1:0], cnt_q, ord_q)};

  // R6 / R8: each step advances the two-bit counter modulo four
  a_r6_step_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> cnt_q == 2'($past(cnt_q) + 2'd1));

  // R4: stalled cycles keep burst state
  a_r4_burst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(cnt_q) && $stable(base_q) && $stable(ord_q)));
endmodule

// File: rtl/nb_op_ctrl.sv
module nb_op_ctrl #(
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stall_i,
  input  logic                 adv_i,
  input  logic                 sel_i,
  input  logic                 rnw_i,
  input  logic [NUM_BYTES-1:0] ben_i,
  output logic                 load_o,
  output logic                 step_o,
  output logic                 pend_valid_o,
  output logic                 pend_rd_o,
  output logic [NUM_BYTES-1:0] pend_ben_o
);
  logic                 act_q;
  logic                 valid_q;
  logic                 rd_q;
  logic [NUM_BYTES-1:0] ben_q;

  assign load_o = !stall_i && !adv_i && sel_i;
  assign step_o = !stall_i && adv_i && act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      valid_q <= 1'b0;
      rd_q    <= 1'b0;
      ben_q   <= '0;
    end else if (!stall_i) begin
      if (!adv_i) begin
        act_q   <= sel_i;
        valid_q <= sel_i;
        if (sel_i) begin
          rd_q  <= rnw_i;
          ben_q <= ben_i;
        end
      end else begin
        // advance continues the previous type, or stays idle
        valid_q <= act_q;
        if (act_q) ben_q <= ben_i;
      end
    end
  end

  assign pend_valid_o = valid_q;
  assign pend_rd_o    = rd_q;
  assign pend_ben_o   = ben_q;

  a_r4_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(valid_q) && $stable(rd_q) && $stable(ben_q) && $stable(act_q)));

  a_r9_adv_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && adv_i && !act_q) |=> !valid_q);
endmodule

// File: rtl/nb_mem_array.sv
module nb_mem_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                      clk_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W/BYTE_W-1:0]  ben_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o
);
  localparam int WORDS     = 1 << ADDR_W;
  localparam int NUM_BYTES = DATA_W / BYTE_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] lane_mask;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    assign lane_mask[b*BYTE_W +: BYTE_W] = {BYTE_W{ben_i[b]}};
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= (mem_q[addr_i] & ~lane_mask) | (wdata_i & lane_mask);
  end

  // flow-through: no output register
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/nobubble_sram.sv
module nobubble_sram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clk_en_ni,
  input  logic                      ce1_ni,
  input  logic                      ce2_i,
  input  logic                      ce2b_ni,
  input  logic                      rnw_i,
  input  logic                      adv_i,
  input  logic                      burst_ilv_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W/BYTE_W-1:0]  byte_en_ni,
  input  logic                      oe_ni,
  input  logic [DATA_W-1:0]         dq_i,
  output logic [DATA_W-1:0]         dq_o,
  output logic                      dq_oe_o
);
  localparam int NUM_BYTES = DATA_W / BYTE_W;

  logic                 stall, sel, load, step;
  logic                 pend_valid, pend_rd;
  logic [NUM_BYTES-1:0] pend_ben;
  logic [ADDR_W-1:0]    cur_addr;
  logic                 mem_we;

  assign stall = clk_en_ni;
  assign sel   = !ce1_ni && ce2_i && !ce2b_ni;

  nb_op_ctrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk_i, .rst_ni,
    .stall_i      (stall),
    .adv_i        (adv_i),
    .sel_i        (sel),
    .rnw_i        (rnw_i),
    .ben_i        (~byte_en_ni),
    .load_o       (load),
    .step_o       (step),
    .pend_valid_o (pend_valid),
    .pend_rd_o    (pend_rd),
    .pend_ben_o   (pend_ben)
  );

  nb_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i, .rst_ni,
    .stall_i    (stall),
    .load_i     (load),
    .step_i     (step),
    .addr_i     (addr_i),
    .ilv_i      (burst_ilv_i),
    .cur_addr_o (cur_addr)
  );

  assign mem_we = !stall && pend_valid && !pend_rd;

  nb_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_mem (
    .clk_i,
    .we_i    (mem_we),
    .addr_i  (cur_addr),
    .ben_i   (pend_ben),
    .wdata_i (dq_i),
    .rdata_o (dq_o)
  );

  assign dq_oe_o = pend_valid && pend_rd && !oe_ni;

  a_r3_oe_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

  a_r1_read_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !adv_i && sel && rnw_i) |=> (dq_oe_o || oe_ni));

  a_r5_deselect_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !adv_i && !sel) |=> !dq_oe_o);
endmodule

// File: tb/nobubble_sram_test.sv
`timescale 1ns/1ps
module nobubble_sram_test;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NB = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clk_en_ni = 1'b0;
  logic          ce1_ni = 1'b1, ce2_i = 1'b0, ce2b_ni = 1'b1;
  logic          rnw_i = 1'b0, adv_i = 1'b0, burst_ilv_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [NB-1:0] byte_en_ni = '1;
  logic          oe_ni = 1'b0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;

  nobubble_sram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(8)) uut (
    .clk_i, .rst_ni, .clk_en_ni, .ce1_ni, .ce2_i, .ce2b_ni, .rnw_i, .adv_i,
    .burst_ilv_i, .addr_i, .byte_en_ni, .oe_ni, .dq_i, .dq_o, .dq_oe_o
  );

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model
  logic [DW-1:0] shadow [1<<AW];
  bit            b_valid = 0, b_rd = 0, b_act = 0, b_ilv = 0;
  logic [AW-1:0] b_base = '0, b_addr = '0;
  logic [1:0]    b_cnt = '0;
  logic [NB-1:0] b_ben = '0;
  logic [DW-1:0] b_wdata = '0;
  int            seq = 0;

  bit            exp_oe_q [$];
  logic [DW-1:0] exp_d_q [$];
  string         exp_tag_q [$];

  task automatic op(input bit stall, input int ce_bad, input bit adv, input bit rnw,
                    input int a, input logic [NB-1:0] ben_n, input bit ilv,
                    input bit oe_n, input string tag);
    clk_en_ni   = stall;
    ce1_ni      = (ce_bad == 1);
    ce2_i       = (ce_bad != 2);
    ce2b_ni     = (ce_bad == 3);
    adv_i       = adv;
    rnw_i       = rnw;
    addr_i      = AW'(a);
    byte_en_ni  = ben_n;
    burst_ilv_i = ilv;
    dq_i        = b_wdata;
    @(posedge clk_i);
    #1;
    oe_ni = oe_n;
    if (!stall) begin
      if (b_valid && !b_rd)
        for (int k = 0; k < NB; k++)
          if (b_ben[k]) shadow[b_addr][8*k +: 8] = b_wdata[8*k +: 8];
      if (!adv) begin
        b_act   = (ce_bad == 0);
        b_valid = b_act;
        if (b_act) begin
          b_rd = rnw; b_base = AW'(a); b_cnt = 2'd0; b_ilv = ilv; b_ben = ~ben_n;
        end
      end else begin
        b_valid = b_act;
        if (b_act) begin
          b_cnt = b_cnt + 2'd1; b_ben = ~ben_n;
        end
      end
      b_addr = {b_base[AW-1:2], b_ilv ? (b_base[1:0] ^ b_cnt) : 2'(b_base[1:0] + b_cnt)};
      if (b_valid && !b_rd) begin
        seq++;
        b_wdata = {8'(seq), 2'b00, b_addr, ~8'(seq), 8'h5A};
      end
    end
    exp_oe_q.push_back(b_valid && b_rd && !oe_n);
    exp_d_q.push_back(shadow[b_addr]);
    exp_tag_q.push_back(tag);
  endtask

  always @(negedge clk_i) begin
    if (exp_oe_q.size() > 0) begin
      bit            e_oe;
      logic [DW-1:0] e_d;
      string         t;
      e_oe = exp_oe_q.pop_front();
      e_d  = exp_d_q.pop_front();
      t    = exp_tag_q.pop_front();
      checks++;
      if (dq_oe_o !== e_oe) begin
        failures++;
        $display("FAIL %s: dq_oe_o actual=%0b expected=%0b", t, dq_oe_o, e_oe);
      end else if (e_oe && dq_o !== e_d) begin
        failures++;
        $display("FAIL %s: dq_o actual=%h expected=%h", t, dq_o, e_d);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) shadow[i] = '0;
    #5 rst_ni = 1'b1;
    #2;
    checks++;
    if (dq_oe_o !== 1'b0) begin // R10
      failures++;
      $display("FAIL R10: dq_oe_o actual=%0b expected=0", dq_oe_o);
    end

    // R2: fill array with back-to-back writes
    for (int i = 0; i < (1 << AW); i++) op(0, 0, 0, 0, i, 4'h0, 0, 0, "R2");
    // R1: back-to-back reads, data in cycle after address
    for (int i = 0; i < (1 << AW); i++) op(0, 0, 0, 1, (i * 7) % (1 << AW), 4'hF, 0, 0, "R1");
    // R11: write then same-address read, no gap
    op(0, 0, 0, 0, 10, 4'h0, 0, 0, "R11");
    op(0, 0, 0, 1, 10, 4'hF, 0, 0, "R11");
    op(0, 0, 0, 0, 11, 4'h0, 0, 0, "R11");
    op(0, 0, 0, 1, 11, 4'hF, 0, 0, "R11");
    // R2: partial byte lanes (lanes 0 and 2 written)
    op(0, 0, 0, 0, 20, 4'b1010, 0, 0, "R2");
    op(0, 0, 0, 1, 20, 4'hF, 0, 0, "R2");
    op(0, 0, 0, 0, 21, 4'b0111, 0, 0, "R2");
    op(0, 0, 0, 1, 21, 4'hF, 0, 0, "R2");
    // R6 linear burst read from 5, then R8 wrap
    op(0, 0, 0, 1, 5, 4'hF, 0, 0, "R6");
    for (int i = 0; i < 3; i++) op(0, 0, 1, 0, 0, 4'hF, 1, 0, "R6");
    for (int i = 0; i < 5; i++) op(0, 0, 1, 0, 0, 4'hF, 1, 0, "R8");
    // R7 interleaved burst read from 6
    op(0, 0, 0, 1, 6, 4'hF, 1, 0, "R7");
    for (int i = 0; i < 7; i++) op(0, 0, 1, 0, 0, 4'hF, 0, 0, "R7");
    // R6 linear burst write from 13, read back singly
    op(0, 0, 0, 0, 13, 4'h0, 0, 0, "R6");
    for (int i = 0; i < 3; i++) op(0, 0, 1, 1, 0, 4'h0, 0, 0, "R6");
    for (int i = 12; i < 16; i++) op(0, 0, 0, 1, i, 4'hF, 0, 0, "R6");
    // R7 interleaved burst write from 27, read back
    op(0, 0, 0, 0, 27, 4'h0, 1, 0, "R7");
    for (int i = 0; i < 3; i++) op(0, 0, 1, 1, 0, 4'h0, 0, 0, "R7");
    for (int i = 24; i < 28; i++) op(0, 0, 0, 1, i, 4'hF, 0, 0, "R7");
    // R5: deselect with each chip select; pending write completes
    op(0, 0, 0, 0, 30, 4'h0, 0, 0, "R5");
    op(0, 1, 0, 1, 31, 4'hF, 0, 0, "R5");
    op(0, 0, 0, 1, 30, 4'hF, 0, 0, "R5");
    op(0, 2, 0, 1, 31, 4'hF, 0, 0, "R5");
    op(0, 3, 0, 0, 31, 4'h0, 0, 0, "R5");
    op(0, 0, 0, 1, 31, 4'hF, 0, 0, "R5");
    // R9: advance after deselect stays idle
    op(0, 1, 0, 1, 32, 4'hF, 0, 0, "R9");
    op(0, 0, 1, 1, 0, 4'hF, 0, 0, "R9");
    op(0, 0, 1, 0, 0, 4'h0, 0, 0, "R9");
    // R4: stalled write completes late; write offered during stall ignored
    op(0, 0, 0, 0, 40, 4'h0, 0, 0, "R4");
    op(1, 0, 0, 0, 41, 4'h0, 0, 0, "R4");
    op(1, 0, 0, 1, 42, 4'hF, 0, 0, "R4");
    op(0, 0, 0, 1, 40, 4'hF, 0, 0, "R4");
    op(0, 0, 0, 1, 41, 4'hF, 0, 0, "R4");
    op(1, 1, 0, 0, 50, 4'h0, 0, 0, "R4");
    op(1, 0, 1, 0, 0, 4'h0, 0, 0, "R4");
    op(0, 0, 0, 1, 50, 4'hF, 0, 0, "R4");
    // R3: output enable blanks a pending read
    op(0, 0, 0, 1, 43, 4'hF, 0, 1, "R3");
    op(1, 0, 0, 1, 44, 4'hF, 0, 0, "R3");
    op(1, 0, 0, 1, 44, 4'hF, 0, 1, "R3");
    op(0, 0, 0, 1, 44, 4'hF, 0, 0, "R3");
    op(0, 1, 0, 0, 0, 4'hF, 0, 0, "R5");
    op(0, 1, 0, 0, 0, 4'hF, 0, 0, "R5");
    @(posedge clk_i);
    @(posedge clk_i);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule